// File: doc/BRIEF.md
# Protection Unit Region Register Bank

This block is the software-visible register file of a memory protection unit that describes each region by a start word and an end word. A 32-bit word bus with a byte offset, read and write strobes, write data and registered read data reaches a region pointer, one start word and one end word per implemented region, and two memory-attribute words. The logic that matches addresses and checks permissions reads this configuration from elsewhere. This block only decodes accesses, stores values, resolves aliases, checks bounds and clears everything on reset.

Four addresses reach each start word and four reach each end word. The first address of each group uses the region pointer as it is. The other three replace the two low bits of the pointer with their alias number. Software can then program four consecutive regions without rewriting the pointer. An access whose effective region is not implemented is dropped without any notice. Every write that is accepted into a start or end word raises a one-cycle flush pulse for the translation cache.

Top module: `mpu_region_bank`

## Requirements
- R1: The region pointer is at byte offset 0xD98. A write stores the low 4 bits of the write data. A read returns those 4 bits zero-extended to 32 bits.
- R2: The start word is reached at 0xD9C, 0xDA4, 0xDAC and 0xDB4, and the end word at 0xDA0, 0xDA8, 0xDB0 and 0xDB8. These are alias numbers 0 to 3, in steps of 8 bytes. Alias 0 selects the region given by the pointer. Alias k>0 selects the pointer with bits [1:0] replaced by k. Writes store all 32 bits unmasked, and reads return them unchanged.
- R3: When the effective region is NUM_REGIONS or greater, a start or end read returns 0, and a start or end write changes no region and raises no flush.
- R4: Each accepted start or end write drives cache_flush high for exactly the cycle after the write, and only then.
- R5: Attribute word 0 is at 0xDC0 and attribute word 1 is at 0xDC4, both full 32-bit read/write. With NUM_REGIONS = 0, writes to them are discarded and they read as 0, as do all start and end reads.
- R6: Reset (rst_n low) clears every start and end word, the region pointer and both attribute words, and drives cache_flush and bus_rdata to 0.
- R7: A read of any offset not listed in R1, R2 or R5 returns 0, and a write to one changes nothing. A misaligned offset (bits [1:0] not 00) counts as unlisted.
- R8: A read strobe in cycle n updates bus_rdata at the end of cycle n, with the value held before any write in that same cycle. bus_rdata holds while no read strobe is present.
- R9: Writes to the region pointer and to the attribute words never raise cache_flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cache_flush | output | 1 | One-cycle pulse after an accepted region write |

## Verification
A corrupted region pointer or a wrong alias substitution shows up as read data from the wrong region. It is visible one cycle after the read strobe that touches the affected region. A bounds check that is off by one, or a region index that is truncated, makes an out-of-range write either raise cache_flush in the next cycle or overwrite a lower region. A later read of that lower region exposes the overwrite. Stale or spurious flush state appears on cache_flush within one cycle of the write, or without any write at all.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;

    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int MAX_REGIONS  = 16;
    localparam int RNUM_W       = $clog2(MAX_REGIONS);
    localparam int ALIAS_COUNT  = 4;
    localparam int ALIAS_STRIDE = 8;

    localparam logic [ADDR_W-1:0] OFS_RNUM  = 12'hD98;
    localparam logic [ADDR_W-1:0] OFS_START = 12'hD9C;
    localparam logic [ADDR_W-1:0] OFS_END   = 12'hDA0;
    localparam logic [ADDR_W-1:0] OFS_ATTR0 = 12'hDC0;
    localparam logic [ADDR_W-1:0] OFS_ATTR1 = 12'hDC4;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RNUM,
        ACC_START,
        ACC_END,
        ACC_ATTR0,
        ACC_ATTR1
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [1:0] alias_idx;
    } acc_dec_t;

endpackage

// File: rtl/mpu_bank_decode.sv
module mpu_bank_decode
    import mpu_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output acc_dec_t          dec_o
);
    always_comb begin
        dec_o.kind      = ACC_NONE;
        dec_o.alias_idx = 2'd0;
        if (addr_i == OFS_RNUM)  dec_o.kind = ACC_RNUM;
        if (addr_i == OFS_ATTR0) dec_o.kind = ACC_ATTR0;
        if (addr_i == OFS_ATTR1) dec_o.kind = ACC_ATTR1;
        // Each alias sits one stride above the previous one.
        for (int k = 0; k < ALIAS_COUNT; k++) begin
            if (addr_i == OFS_START + ADDR_W'(k * ALIAS_STRIDE)) begin
                dec_o.kind      = ACC_START;
                dec_o.alias_idx = 2'(k);
            end
            if (addr_i == OFS_END + ADDR_W'(k * ALIAS_STRIDE)) begin
                dec_o.kind      = ACC_END;
                dec_o.alias_idx = 2'(k);
            end
        end
    end
endmodule

// File: rtl/mpu_bank_region_sel.sv
module mpu_bank_region_sel
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [RNUM_W-1:0] rnum_i,
    input  logic [1:0]        alias_i,
    output logic [RNUM_W-1:0] idx_o,
    output logic              in_range_o
);
    always_comb begin
        idx_o = rnum_i;
        if (alias_i != 2'd0) idx_o[1:0] = alias_i;
    end

    generate
        if (NUM_REGIONS == 0) begin : g_none
            assign in_range_o = 1'b0;
        end else if (NUM_REGIONS >= MAX_REGIONS) begin : g_full
            assign in_range_o = 1'b1;
        end else begin : g_part
            assign in_range_o = ({1'b0, idx_o} < (RNUM_W + 1)'(NUM_REGIONS));
        end
    endgenerate
endmodule

// File: rtl/mpu_bank_region_store.sv
module mpu_bank_region_store
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic              wr_end_i,
    input  logic [RNUM_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] start_o,
    output logic [DATA_W-1:0] end_o
);
    generate
        if (NUM_REGIONS == 0) begin : g_empty
            assign start_o = '0;
            assign end_o   = '0;
        end else begin : g_regs
            logic [NUM_REGIONS-1:0][DATA_W-1:0] start_d, start_q;
            logic [NUM_REGIONS-1:0][DATA_W-1:0] end_d, end_q;

            always_comb begin
                start_d = start_q;
                end_d   = end_q;
                start_o = '0;
                end_o   = '0;
                for (int r = 0; r < NUM_REGIONS; r++) begin
                    if (idx_i == RNUM_W'(r)) begin
                        if (wr_start_i) start_d[r] = wdata_i;
                        if (wr_end_i)   end_d[r]   = wdata_i;
                        start_o = start_q[r];
                        end_o   = end_q[r];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_q <= '0;
                    end_q   <= '0;
                end else begin
                    start_q <= start_d;
                    end_q   <= end_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cache_flush
);
    localparam bit HAS_REGIONS = (NUM_REGIONS > 0);

    typedef struct packed {
        logic [RNUM_W-1:0] rnum;
        logic [DATA_W-1:0] attr0;
        logic [DATA_W-1:0] attr1;
        logic [DATA_W-1:0] rdata;
        logic              flush;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    acc_dec_t          dec;
    logic [RNUM_W-1:0] eff_idx;
    logic              in_range;
    logic              wr_start, wr_end;
    logic [DATA_W-1:0] start_rd, end_rd;
    logic [DATA_W-1:0] rd_val;

    mpu_bank_decode u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    mpu_bank_region_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
        .rnum_i     (ctl_q.rnum),
        .alias_i    (dec.alias_idx),
        .idx_o      (eff_idx),
        .in_range_o (in_range)
    );

    mpu_bank_region_store #(.NUM_REGIONS(NUM_REGIONS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start_i (wr_start),
        .wr_end_i   (wr_end),
        .idx_i      (eff_idx),
        .wdata_i    (bus_wdata),
        .start_o    (start_rd),
        .end_o      (end_rd)
    );

    assign wr_start = bus_wr && (dec.kind == ACC_START) && in_range;
    assign wr_end   = bus_wr && (dec.kind == ACC_END)   && in_range;

    // Read value uses current state only, so a same-cycle write is not seen.
    always_comb begin
        unique case (dec.kind)
            ACC_RNUM:  rd_val = DATA_W'(ctl_q.rnum);
            ACC_START: rd_val = in_range ? start_rd : '0;
            ACC_END:   rd_val = in_range ? end_rd   : '0;
            ACC_ATTR0: rd_val = ctl_q.attr0;
            ACC_ATTR1: rd_val = ctl_q.attr1;
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = wr_start || wr_end;
        if (bus_wr) begin
            unique case (dec.kind)
                ACC_RNUM:  ctl_d.rnum = bus_wdata[RNUM_W-1:0];
                ACC_ATTR0: if (HAS_REGIONS) ctl_d.attr0 = bus_wdata;
                ACC_ATTR1: if (HAS_REGIONS) ctl_d.attr1 = bus_wdata;
                default:   ;
            endcase
        end
        if (bus_rd) ctl_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign bus_rdata   = ctl_q.rdata;
    assign cache_flush = ctl_q.flush;
endmodule

// File: rtl/mpu_region_bank_chk.sv
module mpu_region_bank_chk
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cache_flush
);
    logic listed;
    always_comb begin
        listed = (bus_addr == OFS_RNUM) || (bus_addr == OFS_ATTR0) ||
                 (bus_addr == OFS_ATTR1);
        for (int k = 0; k < 2 * ALIAS_COUNT; k++)
            if (bus_addr == OFS_START + ADDR_W'(4 * k)) listed = 1'b1;
    end

    // R4: a flush pulse is always preceded by a write strobe
    p_flush_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cache_flush |-> $past(bus_wr));

    // R9: pointer writes never flush
    p_rnum_no_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_RNUM) |=> !cache_flush);

    // R7: unlisted offsets read as zero
    p_unlisted_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !listed) |=> (bus_rdata == '0));

    // R1: pointer read is zero-extended
    p_rnum_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RNUM) |=> (bus_rdata[DATA_W-1:RNUM_W] == '0));

    // R8: read data holds without a read strobe
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    generate
        if (NUM_REGIONS == 0) begin : g_zero
            // R3: no region is implemented, so nothing is ever accepted
            p_no_flush_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !cache_flush);
        end
    endgenerate
endmodule

bind mpu_region_bank mpu_region_bank_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .cache_flush (cache_flush)
);

// File: tb/tb_mpu_region_bank.sv
module tb_mpu_region_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata0;
    logic        flush, flush0;

    int n_chk = 0;
    int n_bad = 0;
    logic        fl_seen, fl0_seen;
    logic [31:0] v, v0;

    always #4 clk = ~clk;

    mpu_region_bank #(.NUM_REGIONS(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .cache_flush(flush));

    mpu_region_bank #(.NUM_REGIONS(0)) dut0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .cache_flush(flush0));

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        fl_seen = flush; fl0_seen = flush0;
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        v = rdata; v0 = rdata0;
        bus_rd = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        apply_reset();
        check("R6 flush after reset", 32'(flush), 0);
        check("R6 rdata after reset", rdata, 0);
        do_read(12'hD98); check("R6 pointer reset", v, 0);
        do_read(12'hD9C); check("R6 start0 reset", v, 0);
        do_read(12'hDA0); check("R6 end0 reset", v, 0);
        do_read(12'hDC0); check("R6 attr0 reset", v, 0);
        do_read(12'hDC4); check("R6 attr1 reset", v, 0);
    endtask

    task automatic t_pointer();
        do_write(12'hD98, 32'h0000_005A);
        check("R9 pointer write no flush", 32'(fl_seen), 0);
        do_read(12'hD98); check("R1 pointer keeps low 4 bits", v, 32'hA);
    endtask

    task automatic t_direct();
        do_write(12'hD98, 5);
        do_write(12'hD9C, 32'hDEAD_BEEF);
        check("R4 flush after start write", 32'(fl_seen), 1);
        check("R5 empty bank no flush", 32'(fl0_seen), 0);
        @(negedge clk);
        check("R4 flush lasts one cycle", 32'(flush), 0);
        do_write(12'hDA0, 32'h0000_FFE1);
        check("R4 flush after end write", 32'(fl_seen), 1);
        do_read(12'hD9C);
        check("R2 start5 readback", v, 32'hDEAD_BEEF);
        check("R5 empty bank start read", v0, 0);
        do_read(12'hDA0); check("R2 end5 readback", v, 32'h0000_FFE1);
    endtask

    task automatic t_alias();
        do_write(12'hD98, 4);
        do_write(12'hD9C, 32'h4444_0000);
        do_write(12'hD98, 5);
        do_write(12'hDA4, 32'hA1A1_0005);
        do_write(12'hDAC, 32'hA2A2_0006);
        do_write(12'hDB4, 32'hA3A3_0007);
        do_write(12'hD98, 4);
        do_read(12'hD9C); check("R2 alias0 uses pointer", v, 32'h4444_0000);
        do_read(12'hDA4); check("R2 alias1 from ptr4 -> region5", v, 32'hA1A1_0005);
        do_write(12'hD98, 7);
        do_read(12'hD9C); check("R2 alias3 wrote region7", v, 32'hA3A3_0007);
        do_write(12'hD98, 6);
        do_read(12'hD9C); check("R2 alias2 wrote region6", v, 32'hA2A2_0006);
        do_write(12'hD98, 3);
        do_write(12'hDA8, 32'h0101_0101);
        do_write(12'hD98, 0);
        do_write(12'hDB0, 32'h0202_0202);
        do_write(12'hD98, 1);
        do_read(12'hDA0); check("R2 end alias1 ptr3 -> region1", v, 32'h0101_0101);
        do_write(12'hD98, 2);
        do_read(12'hDA0); check("R2 end alias2 ptr0 -> region2", v, 32'h0202_0202);
    endtask

    task automatic t_range();
        do_write(12'hD98, 1);
        do_write(12'hD9C, 32'h1111_1111);
        do_write(12'hD98, 9);
        do_write(12'hD9C, 32'hBAD0_0009);
        check("R3 out-of-range write no flush", 32'(fl_seen), 0);
        do_read(12'hD9C); check("R3 out-of-range read zero", v, 0);
        do_write(12'hD98, 14);
        do_write(12'hDA8, 32'hBAD0_000D);
        check("R3 alias to region13 no flush", 32'(fl_seen), 0);
        do_write(12'hD98, 1);
        do_read(12'hD9C); check("R3 region1 untouched", v, 32'h1111_1111);
        do_write(12'hD98, 5);
        do_read(12'hDA0); check("R3 region5 end untouched", v, 32'h0000_FFE1);
    endtask

    task automatic t_attr();
        do_write(12'hDC0, 32'h0044_FF00);
        check("R9 attr0 write no flush", 32'(fl_seen), 0);
        do_write(12'hDC4, 32'h1234_5678);
        check("R9 attr1 write no flush", 32'(fl_seen), 0);
        do_read(12'hDC0);
        check("R5 attr0 readback", v, 32'h0044_FF00);
        check("R5 empty bank attr0 zero", v0, 0);
        do_read(12'hDC4);
        check("R5 attr1 readback", v, 32'h1234_5678);
        check("R5 empty bank attr1 zero", v0, 0);
    endtask

    task automatic t_unlisted();
        do_write(12'hD90, 32'hFFFF_FFFF);
        do_read(12'hD90); check("R7 unlisted read zero", v, 0);
        do_write(12'hD98, 1);
        do_write(12'hD9D, 32'h0000_CAFE);
        check("R7 misaligned write no flush", 32'(fl_seen), 0);
        do_read(12'hD9D); check("R7 misaligned read zero", v, 0);
        do_read(12'hD9C); check("R7 region1 unchanged", v, 32'h1111_1111);
        do_read(12'hDBC); check("R7 gap offset zero", v, 0);
        do_read(12'hDC8); check("R7 past attr zero", v, 0);
        do_read(12'hD98); check("R7 pointer unchanged", v, 1);
    endtask

    task automatic t_timing();
        do_read(12'hDC4);
        repeat (3) @(negedge clk);
        check("R8 rdata holds without strobe", rdata, 32'h1234_5678);
        @(negedge clk);
        bus_addr = 12'hDC0; bus_wdata = 32'h7777_0000; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R8 same-cycle read sees old value", rdata, 32'h0044_FF00);
        do_read(12'hDC0); check("R8 later read sees new value", v, 32'h7777_0000);
    endtask

    task automatic t_reset_again();
        apply_reset();
        do_read(12'hD98); check("R6 pointer cleared", v, 0);
        do_read(12'hDC0); check("R6 attr0 cleared", v, 0);
        do_write(12'hD98, 5);
        do_read(12'hD9C); check("R6 start5 cleared", v, 0);
        do_read(12'hDA0); check("R6 end5 cleared", v, 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pointer();
        t_direct();
        t_alias();
        t_range();
        t_attr();
        t_unlisted();
        t_timing();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule